// File: doc/BRIEF.md
# Halfband Interpolate-by-Two Stage for I/Q Streams

This stage doubles the sample rate of a complex baseband stream carried as two parallel 16-bit signed words, one in-phase (I) and one quadrature (Q). Each lane inserts a zero after every accepted sample and low-pass filters the result with a fixed symmetric 19-tap halfband kernel. The kernel has integer taps 1, 0, -17, 0, 87, 0, -299, 0, 1252, 2048, 1252, 0, -299, 0, 87, 0, -17, 0, 1. Both lanes use the same kernel and share one sequencer, so their outputs stay aligned.

The clock runs at the output rate. The block takes at most one input sample every two clocks through a valid/ready handshake, and it presents two output words per accepted sample. The first output word is the centre phase: the sample accepted five samples earlier, passed through exactly. The second output word is the midpoint phase: a weighted sum over the ten most recent samples, rounded and clamped to 16 bits. Because the zero-stuffed kernel has a DC gain of 2048, the sum is normalised by a right shift of 11.

A bypass input is sampled together with each accepted sample. A bypassed sample is repeated unchanged on both of its output slots. The filter history takes in a zero in its place, which also keeps the filter logic quiet. The sequencer has three states:
- `ST_IDLE`: no sample is in flight.
- `ST_CTR`: the centre phase is being formed, and input is not accepted.
- `ST_MID`: the midpoint phase is being formed, and input is accepted.

Its transitions are:
- `ST_IDLE`→`ST_CTR` on an accepted sample.
- `ST_CTR`→`ST_MID` always.
- `ST_MID`→`ST_CTR` when a new sample is accepted.
- `ST_MID`→`ST_IDLE` when no sample is offered.

Top module: `hbi_interp2`

## Requirements
- R1: While reset is low and just after it is released, `out_valid` is 0, `in_ready` is 1 and both output words are 0. The filter history is cleared, so the first outputs after reset behave as if all earlier inputs were zero.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for exactly the one clock that follows each acceptance, so a value offered during that clock is ignored.
- R3: Each accepted sample yields exactly two output words, with `out_valid` high in the second and third clock after the acceptance edge. When no sample is offered while `in_ready` is high, `out_valid` is low one clock after the last pending output.
- R4: For the n-th sample x[n] since reset, the first output word equals x[n-5] exactly (zero when n<5).
- R5: For the n-th sample, the second output word equals 1·(x[n]+x[n-9]) − 17·(x[n-1]+x[n-8]) + 87·(x[n-2]+x[n-7]) − 299·(x[n-3]+x[n-6]) + 1252·(x[n-4]+x[n-5]), divided by 2048. A constant input therefore reproduces itself.
- R6: The division by 2048 rounds half up: 1024 is added before an arithmetic right shift by 11.
- R7: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: The I and Q lanes are computed identically and independently from `in_i` and `in_q`.
- R9: A sample accepted with `bypass`=1 appears unchanged on both of its output words. For later filtered outputs it counts as a zero input.
- R10: The bypass choice is fixed at acceptance: changing `bypass` after the acceptance edge does not alter that sample's two output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Sampled with each accepted sample; 1 selects pass-through |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample on this edge |
| in_i | input | DATA_W | In-phase input sample, signed |
| in_q | input | DATA_W | Quadrature input sample, signed |
| out_valid | output | 1 | Output words are valid this clock |
| out_i | output | DATA_W | In-phase output word, signed |
| out_q | output | DATA_W | Quadrature output word, signed |

## Verification
The assertions take `in_valid` and the input words as meaningful only on an edge where `in_ready` is high. They also assume that `bypass` matters only at that edge and that reset is held for at least one full clock. The stimulus drives data, `bypass` and `in_valid` on falling edges and drops `in_valid` just after each acceptance. A junk word is offered deliberately during a not-ready clock, and `bypass` is flipped right after each acceptance. All of these stay within what the assertions expect. Any sample rate at or below half the clock is allowed, including idle gaps.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CTR  = 2'd1,
        ST_MID  = 2'd2
    } hbi_state_e;

    localparam int NLANE   = 2;
    localparam int NPAIR   = 5;
    localparam int HIST    = 2 * NPAIR;
    localparam int CTR_IDX = NPAIR;
    localparam int GAIN_SH = 11;

    // Nonzero even taps, folded: pair j multiplies sample j and sample HIST-1-j.
    function automatic int pair_coef(input int j);
        case (j)
            0:       return 1;
            1:       return -17;
            2:       return 87;
            3:       return -299;
            default: return 1252;
        endcase
    endfunction

endpackage

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic bypass,
    output logic in_ready,
    output logic shift_en,
    output logic zero_fill,
    output logic byp_sel,
    output logic mid_sel,
    output logic out_en,
    output logic out_valid
);

    hbi_state_e state_q, state_d;
    logic       byp_q;
    logic       valid_q;

    assign in_ready  = (state_q != ST_CTR);
    assign shift_en  = in_valid && in_ready;
    assign zero_fill = bypass;
    assign mid_sel   = (state_q == ST_MID);
    assign out_en    = (state_q != ST_IDLE);
    assign byp_sel   = byp_q;
    assign out_valid = valid_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (shift_en) state_d = ST_CTR;
            ST_CTR:  state_d = ST_MID;
            ST_MID:  state_d = shift_en ? ST_CTR : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            byp_q   <= 1'b0;
        end else begin
            valid_q <= out_en;
            if (shift_en) byp_q <= bypass;
        end
    end

    AST_ACCEPT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !in_ready); // R2

    AST_PAIR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ##1 out_valid ##1 out_valid); // R3

    AST_GAP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> ##1 !out_valid); // R3

endmodule

// File: rtl/hbi_lane.sv
module hbi_lane
    import hbi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     zero_fill,
    input  logic                     byp_sel,
    input  logic                     mid_sel,
    input  logic                     out_en,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout
);

    localparam int ACC_W = DATA_W + 13;
    localparam int MAX_I = (2 ** (DATA_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(MAX_I);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (GAIN_SH - 1);

    logic signed [DATA_W-1:0] tap_q [HIST];
    logic signed [DATA_W-1:0] raw_q;
    logic signed [ACC_W-1:0]  prod_w [NPAIR];
    logic signed [ACC_W-1:0]  acc_w;
    logic signed [ACC_W-1:0]  rnd_w;
    logic signed [ACC_W-1:0]  shf_w;
    logic signed [DATA_W-1:0] mid_w;

    // History line: a bypassed sample enters as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST; i++) tap_q[i] <= '0;
            raw_q <= '0;
        end else if (shift_en) begin
            tap_q[0] <= zero_fill ? '0 : din;
            for (int i = 1; i < HIST; i++) tap_q[i] <= tap_q[i-1];
            raw_q <= din;
        end
    end

    // Folded symmetric products for the midpoint phase.
    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        localparam int CJ = pair_coef(j);
        logic signed [DATA_W:0] psum_w;
        assign psum_w    = DATA_W'(0) + {tap_q[j][DATA_W-1], tap_q[j]}
                         + {tap_q[HIST-1-j][DATA_W-1], tap_q[HIST-1-j]};
        assign prod_w[j] = ACC_W'(psum_w) * ACC_W'(CJ);
    end

    always_comb begin
        acc_w = '0;
        for (int j = 0; j < NPAIR; j++) acc_w = acc_w + prod_w[j];
    end

    assign rnd_w = acc_w + HALF;
    assign shf_w = rnd_w >>> GAIN_SH;

    always_comb begin
        if (shf_w > MAXV)      mid_w = MAXV[DATA_W-1:0];
        else if (shf_w < MINV) mid_w = MINV[DATA_W-1:0];
        else                   mid_w = shf_w[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (out_en) dout <= byp_sel ? raw_q : (mid_sel ? mid_w : tap_q[CTR_IDX]);
    end

    logic flat_w;
    always_comb begin
        flat_w = 1'b1;
        for (int i = 1; i < HIST; i++)
            if (tap_q[i] != tap_q[0]) flat_w = 1'b0;
    end

    AST_DC_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mid_sel && !byp_sel && flat_w) |=> (dout == $past(tap_q[0]))); // R5

endmodule

// File: rtl/hbi_interp2.sv
module hbi_interp2
    import hbi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bypass,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);

    logic shift_en, zero_fill, byp_sel, mid_sel, out_en;
    logic signed [DATA_W-1:0] lane_in  [NLANE];
    logic signed [DATA_W-1:0] lane_out [NLANE];

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;
    assign out_i      = lane_out[0];
    assign out_q      = lane_out[1];

    hbi_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bypass    (bypass),
        .in_ready  (in_ready),
        .shift_en  (shift_en),
        .zero_fill (zero_fill),
        .byp_sel   (byp_sel),
        .mid_sel   (mid_sel),
        .out_en    (out_en),
        .out_valid (out_valid)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        hbi_lane #(.DATA_W(DATA_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (shift_en),
            .zero_fill (zero_fill),
            .byp_sel   (byp_sel),
            .mid_sel   (mid_sel),
            .out_en    (out_en),
            .din       (lane_in[g]),
            .dout      (lane_out[g])
        );
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && bypass) |=> ##1 (out_i == $past(in_i, 2))
                                            ##1 (out_i == $past(in_i, 3))); // R9

endmodule

// File: tb/hbi_interp2_tb.sv
module hbi_interp2_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bypass = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    hbi_interp2 #(.DATA_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
        .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Impulse of 2048: {input, centre word, midpoint word} per sample.
    localparam int IMP_TAB [11][3] = '{
        '{2048, 0, 1},   '{0, 0, -17},   '{0, 0, 87},  '{0, 0, -299},
        '{0, 0, 1252},   '{0, 2048, 1252}, '{0, 0, -299}, '{0, 0, 87},
        '{0, 0, -17},    '{0, 0, 1},     '{0, 0, 0}
    };

    int    exp_i [$];
    int    exp_q [$];
    string exp_tag [$];
    int    fin_i [512];
    int    fin_q [512];
    int    nsamp = 0;
    bit    seen_hi = 0;
    bit    seen_lo = 0;

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int kern(input int k);
        case (k)
            0, 18: return 1;
            2, 16: return -17;
            4, 14: return 87;
            6, 12: return -299;
            8, 10: return 1252;
            9:     return 2048;
            default: return 0;
        endcase
    endfunction

    // Direct convolution of the zero-stuffed stream, then round and clamp.
    function automatic int conv(input int m, input bit q);
        int acc = 0;
        for (int k = 0; k < 19; k++) begin
            int idx = m - k;
            if (idx >= 0 && (idx % 2) == 0)
                acc += kern(k) * (q ? fin_q[idx/2] : fin_i[idx/2]);
        end
        acc = (acc + 1024) >>> 11;
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_i.size() == 0) begin
                total++; bad++;
                $display("FAIL R3 actual=out_valid expected=no output");
            end else begin
                string t;
                int ei, eq;
                ei = exp_i.pop_front();
                eq = exp_q.pop_front();
                t  = exp_tag.pop_front();
                chk({t, " I"}, int'(out_i), ei);
                chk({t, "/R8 Q"}, int'(out_q), eq);
                if (t == "R7" && out_i == 16'sd32767)  seen_hi = 1;
                if (t == "R7" && out_q == -16'sd32768) seen_lo = 1;
            end
        end
    end

    task automatic drive(input int vi, input int vq, input bit b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_i     = 16'(vi);
        in_q     = 16'(vq);
        bypass   = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        bypass   = ~b;   // R10: a late change must not affect this sample
    endtask

    task automatic feed(input int vi, input int vq, input bit b, input string tag);
        int n;
        n = nsamp;
        fin_i[n] = b ? 0 : vi;
        fin_q[n] = b ? 0 : vq;
        nsamp++;
        if (b) begin
            exp_i.push_back(vi); exp_q.push_back(vq); exp_tag.push_back("R9");
            exp_i.push_back(vi); exp_q.push_back(vq); exp_tag.push_back("R10");
        end else begin
            exp_i.push_back(conv(2*n-1, 0)); exp_q.push_back(conv(2*n-1, 1));
            exp_tag.push_back(tag == "R5" ? "R4" : tag);
            exp_i.push_back(conv(2*n, 0));   exp_q.push_back(conv(2*n, 1));
            exp_tag.push_back(tag);
        end
        drive(vi, vq, b);
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
        chk("R3 pending outputs", exp_i.size(), 0);
        chk("R3 idle out_valid", int'(out_valid), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_i", int'(out_i), 0);
        chk("R1 out_q", int'(out_q), 0);
        rst_n = 1'b1;
        nsamp = 0;
        @(negedge clk);
        chk("R1 out_valid after release", int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        do_reset();

        // Impulse table: R4 centre, R5 midpoint, R8 Q is the negated copy.
        for (int r = 0; r < 11; r++) begin
            exp_i.push_back(IMP_TAB[r][1]);  exp_q.push_back(-IMP_TAB[r][1]);
            exp_tag.push_back("R4");
            exp_i.push_back(IMP_TAB[r][2]);  exp_q.push_back(-IMP_TAB[r][2]);
            exp_tag.push_back("R5");
            drive(IMP_TAB[r][0], -IMP_TAB[r][0], 1'b0);
        end
        drain();

        // Reset mid-stream must clear history (R1).
        feed(30000, -30000, 0, "R5");
        feed(30000, -30000, 0, "R5");
        drain();
        do_reset();

        // R2: a word offered while not ready is ignored.
        feed(100, -50, 0, "R2");
        in_i = 16'sh6000; in_q = 16'sh6000; in_valid = 1'b1;
        @(negedge clk);
        chk("R2 in_ready low after accept", int'(in_ready), 0);
        @(posedge clk); #1; in_valid = 1'b0;
        feed(200, 300, 0, "R2");
        for (int r = 0; r < 10; r++) feed(0, 0, 0, "R2");
        drain();

        // R6: half-way values round up (1024 -> 1 and -8.5 -> -8).
        feed(1024, -1024, 0, "R6");
        for (int r = 0; r < 10; r++) feed(0, 0, 0, "R6");
        drain();

        // R7: pattern that matches the tap signs overshoots full scale.
        for (int r = 0; r < 10; r++) begin
            int s;
            s = ((r % 2) == 0) ? 1 : -1;
            if (r >= 5) s = -s;
            feed(s * 32767, -s * 32767 - 1, 0, "R7");
        end
        for (int r = 0; r < 10; r++) feed(0, 0, 0, "R7");
        drain();
        chk("R7 saw I clamp at 32767", int'(seen_hi), 1);
        chk("R7 saw Q clamp at -32768", int'(seen_lo), 1);

        // R5/R8: pseudo-random stream, independent lanes.
        lfsr = 32'h1ACE_B00C;
        for (int r = 0; r < 200; r++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            feed(int'($signed(lfsr[15:0])), int'($signed(lfsr[31:16])), 0, "R5");
        end
        drain();

        // R9/R10: bypassed samples pass through and enter history as zero.
        do_reset();
        for (int r = 0; r < 6; r++) feed(5000 + r * 1000, -7000 + r * 500, 0, "R5");
        for (int r = 0; r < 4; r++) feed(-12345 + r, 23456 - r, 1, "R9");
        for (int r = 0; r < 12; r++) feed(r * 300, -r * 200, 0, "R9");
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule